// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives an external bus host read and write access to a bank of 8-bit registers through an 8-bit register pointer. It oversamples SCL and SDA with the system clock, detects START, repeated START and STOP, and matches a fixed 7-bit target address. After the write-direction address, the host sends a pointer byte. Data bytes that follow are written to the bank. A repeated START with the read-direction address makes the target return the bank contents instead. The pointer moves on by one after every byte, in both directions.

The target never holds SCL, because it has no SCL driver. When it cannot take a byte, it answers with a NACK instead. It is active only while both the undervoltage-ok input and the configuration-complete input are high. The register bank sits outside the block and is reached through a simple address, write-strobe and read-data port.

Top module: `i2c_reg_target`

## Requirements
- R1: While `rst` is high, `sda_oe` and `reg_wr` are low in the cycle after each clock edge.
- R2: A byte after START whose upper seven bits equal `TGT_ADDR` is acknowledged in the ninth SCL period. Bit 0 of that byte selects the direction: 0 means write and 1 means read. Any other address gets a NACK, and SDA stays released until the next START.
- R3: After a write-direction address, the next acknowledged byte loads the register pointer.
- R4: Each acknowledged data byte in a write gives a single-cycle `reg_wr` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. `reg_addr` is one higher in the following cycle, so consecutive bytes fill consecutive registers.
- R5: After a repeated START with the read-direction address, the target sends the contents of the pointed register, MSB first.
- R6: When the host ACKs a read byte, the pointer advances and the next register is sent. When the host NACKs, the target releases SDA and sends nothing more.
- R7: On auto-increment, the pointer wraps from 0xFF to 0x00.
- R8: If `busy` is high when a received byte ends, the byte gets a NACK, nothing is written, and the transaction is dropped.
- R9: Communication is enabled only while `uv_ok` and `cfg_done` are both high. While it is disabled there are no ACKs and no writes. Registers written earlier keep their values.
- R10: The target starts pulling SDA low only while SCL is low.
- R11: After a STOP, bytes clocked without a new START get no ACK and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| uv_ok | input | 1 | Undervoltage comparator reports supply good |
| cfg_done | input | 1 | Configuration complete |
| busy | input | 1 | Target cannot accept data; refuse with NACK |
| reg_addr | output | 8 | Register pointer / bank address |
| reg_wr | output | 1 | Single-cycle bank write strobe |
| reg_wdata | output | 8 | Bank write data |
| reg_rdata | input | 8 | Bank read data for `reg_addr` |

## Verification
If the pointer goes wrong, the damage shows on the `reg_addr` of the next write strobe, or in the first data byte of the next read. A bench that tracks the expected pointer therefore catches it within one byte. If the phase state or the bit count goes wrong, the ACK is missing or moved in the ninth SCL period of the very byte where the error happens. Unwanted bank writes or an unwanted hold of SDA appear as soon as the byte ends. The bench replays addressing, pointer loading, sequential transfers, wrap, busy refusal, enable gating and the effect of STOP. It compares every strobe and every returned byte against its own shadow of the bank.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe;
  logic         scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
      scl_q    <= scl_pipe[TOP];
      sda_q    <= sda_pipe[TOP];
    end
  end

  assign scl_s     = scl_pipe[TOP];
  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter int          AW       = 7,
  parameter int          DW       = 8,
  parameter logic [6:0]  TGT_ADDR = 7'h2A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          comm_en,
  input  logic          busy,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ptr,
  output logic          wr_stb,
  output logic [DW-1:0] wdata,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  tgt_state_e    state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg, txsh;
  logic          rw, acked, rx_phase;

  assign rx_phase = (state == ST_DEV) || (state == ST_PTR) || (state == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      acked  <= 1'b0;
      wr_stb <= 1'b0;
      wdata  <= '0;
      sda_oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (wr_stb) ptr <= ptr + 1'b1;
      if (!comm_en) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise && rx_phase) begin
          shreg  <= {shreg[DW-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end
        if (scl_rise && state == ST_RD) bitcnt <= bitcnt + 1'b1;
        if (scl_rise && state == ST_RD_ACK) begin
          acked <= ~sda_s;
          if (!sda_s) ptr <= ptr + 1'b1;
        end
        if (scl_fall) begin
          case (state)
            ST_DEV: if (bitcnt == LAST) begin
              if (shreg[DW-1:DW-AW] == TGT_ADDR && !busy) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_PTR: if (bitcnt == LAST) begin
              if (!busy) begin
                sda_oe <= 1'b1;
                ptr    <= shreg;
                state  <= ST_PTR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WR: if (bitcnt == LAST) begin
              if (!busy) begin
                sda_oe <= 1'b1;
                wr_stb <= 1'b1;
                wdata  <= shreg;
                state  <= ST_WR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_DEV_ACK: begin
              bitcnt <= '0;
              if (rw) begin
                txsh   <= rdata;
                sda_oe <= ~rdata[DW-1];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
            ST_PTR_ACK, ST_WR_ACK: begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
            ST_RD: begin
              if (bitcnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else if (bitcnt != '0) begin
                txsh   <= txsh << 1;
                sda_oe <= ~txsh[DW-2];
              end
            end
            ST_RD_ACK: begin
              bitcnt <= '0;
              if (acked) begin
                txsh   <= rdata;
                sda_oe <= ~rdata[DW-1];
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  TGT_ADDR    = 7'h2A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       uv_ok,
  input  logic       cfg_done,
  input  logic       busy,
  output logic [7:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, comm_en;

  assign comm_en = uv_ok & cfg_done;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_core #(.AW(7), .DW(8), .TGT_ADDR(TGT_ADDR)) u_core (
    .clk(clk), .rst(rst), .comm_en(comm_en), .busy(busy), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rdata(reg_rdata), .ptr(reg_addr), .wr_stb(reg_wr),
    .wdata(reg_wdata), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic       busy,
  input logic       uv_ok,
  input logic       cfg_done
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!sda_oe && !reg_wr));
  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);
  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr);
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_addr == $past(reg_addr) + 8'd1));
  // R8
  busy_nowr_chk: assert property (@(posedge clk) disable iff (rst) busy |=> !reg_wr);
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(uv_ok && cfg_done) |=> (!reg_wr && !sda_oe));
endmodule

bind i2c_reg_target i2c_tgt_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .busy(busy), .uv_ok(uv_ok), .cfg_done(cfg_done)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6 * CLK_PERIOD;
  localparam logic [6:0] DEV = 7'h2A;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, host_low = 1'b0;
  logic uv_ok = 1'b1, cfg_done = 1'b1, busy = 1'b0;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] bank [256];
  logic [7:0] exp_mem [256];
  wr_item_t   exp_q [$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic sda;

  assign sda = ~(host_low | sda_oe);
  assign reg_rdata = bank[reg_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .uv_ok(uv_ok), .cfg_done(cfg_done), .busy(busy), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_wr) bank[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (!rst && reg_wr) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4/R8/R9/R11 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == {e.a, e.d}, "R4 write strobe",
            {reg_addr, reg_wdata}, {e.a, e.d});
      end
    end
  end

  // R10: count target drive starts seen while SCL is high
  int drive_hi = 0;
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe && !oe_prev && scl) drive_hi++;
    oe_prev <= sda_oe;
  end

  task automatic wbit(input logic b);
    host_low = ~b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic rbit(output logic b);
    host_low = 1'b0; #Q; scl = 1'b1; #Q; b = sda; #Q; scl = 1'b0; #Q;
  endtask

  task automatic h_start();
    host_low = 1'b0; #Q; scl = 1'b1; #Q; host_low = 1'b1; #Q; scl = 1'b0; #Q;
  endtask

  task automatic h_stop();
    host_low = 1'b1; #Q; scl = 1'b1; #Q; host_low = 1'b0; #Q;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~host_ack);
  endtask

  task automatic write_seq(input logic [7:0] p, input int n, input logic [7:0] seed, input string req);
    logic ack;
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, {req, " addr ack"}, ack, 1);
    wbyte(p, ack);           chk(ack, {req, " ptr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a, d;
      a = p + 8'(i);
      d = seed ^ 8'(i * 37);
      exp_q.push_back('{a: a, d: d});
      exp_mem[a] = d;
      wbyte(d, ack); chk(ack, {req, " data ack"}, ack, 1);
    end
    h_stop();
    #(4*Q);
  endtask

  task automatic read_seq(input logic [7:0] p, input int n, input string req);
    logic ack;
    logic [7:0] v;
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, {req, " addr ack"}, ack, 1);
    wbyte(p, ack);           chk(ack, {req, " ptr ack"}, ack, 1);
    h_start();
    wbyte({DEV, 1'b1}, ack); chk(ack, {req, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(v, i != n - 1);
      chk(v == exp_mem[8'(p + 8'(i))], {req, " read data"}, v, exp_mem[8'(p + 8'(i))]);
    end
    #(Q/2);
    chk(sda_oe == 1'b0, "R6 SDA released after NACK", sda_oe, 0);
    h_stop();
    #(4*Q);
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(sda_oe == 1'b0 && reg_wr == 1'b0, "R1 reset outputs", {sda_oe, reg_wr}, 0);
    @(negedge clk); rst = 1'b0;
    #(4*Q);

    // R2 wrong address is refused
    h_start();
    wbyte({7'h15, 1'b0}, ack); chk(!ack, "R2 foreign address nack", ack, 0);
    wbyte(8'h33, ack);         chk(!ack, "R2 stays silent until START", ack, 0);
    h_stop(); #(4*Q);

    // R3 R4 single write then sequential write
    write_seq(8'h10, 1, 8'hA5, "R3 R4 single");
    write_seq(8'h20, 3, 8'h5C, "R4 sequential");
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);

    // R5 R6 reads with host ack then nack
    read_seq(8'h10, 1, "R5 single read");
    read_seq(8'h20, 3, "R6 sequential read");
    read_seq(8'h80, 2, "R5 untouched regs");

    // R7 wrap in write and read
    write_seq(8'hFF, 2, 8'hC3, "R7 wrap write");
    read_seq(8'hFE, 3, "R7 wrap read");

    // R8 busy on address, then busy on data byte
    busy = 1'b1;
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(!ack, "R8 busy address nack", ack, 0);
    h_stop(); #(4*Q);
    busy = 1'b0;
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, "R8 addr ack when idle", ack, 1);
    wbyte(8'h40, ack);       chk(ack, "R8 ptr ack", ack, 1);
    busy = 1'b1;
    wbyte(8'hEE, ack);       chk(!ack, "R8 busy data nack", ack, 0);
    h_stop(); #(4*Q);
    busy = 1'b0;
    read_seq(8'h40, 1, "R8 no write while busy");

    // R9 enable gating
    uv_ok = 1'b0;
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(!ack, "R9 uv low nack", ack, 0);
    h_stop(); #(4*Q);
    uv_ok = 1'b1; cfg_done = 1'b0;
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(!ack, "R9 cfg low nack", ack, 0);
    h_stop(); #(4*Q);
    cfg_done = 1'b1;
    read_seq(8'h21, 2, "R9 contents kept");

    // R11 bytes after STOP without START
    h_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, "R11 addr ack", ack, 1);
    wbyte(8'h50, ack);       chk(ack, "R11 ptr ack", ack, 1);
    h_stop();
    #(2*Q); scl = 1'b0; #Q;
    wbyte(8'h77, ack);       chk(!ack, "R11 no ack after STOP", ack, 0);
    wbyte(8'h78, ack);       chk(!ack, "R11 still idle", ack, 0);
    h_stop(); #(4*Q);
    read_seq(8'h50, 1, "R11 no write after STOP");

    chk(drive_hi == 0, "R10 drive only with SCL low", drive_hi, 0);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule